// File: doc/BRIEF.md
# Multiple-Register Transfer Address Sequencer

This block runs one block-transfer instruction that moves a set of general registers to or from consecutive memory words. A caller presents a base address, a register-select mask and five control flags: pre-step, ascending, privileged-bank, writeback and load. It then pulses `start_i`. The sequencer walks the mask one selected register at a time and issues one word access per register on a simple request/ready memory port. It reads store data from, or writes load data into, a register file through an index port. When it finishes it reports the final running address so the base register can be updated.

In ascending mode the registers are visited from the lowest index up and the address grows by four bytes per access. In descending mode they are visited from the highest index down and the address shrinks. The pre-step flag decides whether the four-byte step is applied before or after each access. Two encodings are refused with a trap and cause no memory activity: a mask that selects the top register, and a set privileged-bank flag.

The controller has four states. IDLE waits for a start. XFER issues one access per selected register. DONE pulses completion and offers the base writeback. TRAP pulses completion together with the trap flag. The transitions are:
- IDLE→TRAP: start with a refused encoding.
- IDLE→DONE: start with an empty mask.
- IDLE→XFER: any other start.
- XFER→XFER: ready is low, or further registers are still pending.
- XFER→DONE: ready arrives for the last pending register.
- DONE→IDLE and TRAP→IDLE: always, after one cycle.

Top module: `blk_xfer_seq`

## Requirements
- R1: A start whose mask has bit 15 (the top register) set, or whose privileged-bank flag is set, is answered one cycle later by `done_o` and `trap_o` together. That start issues no memory request and no register-file write.
- R2: With `pre_i`=1 each access address is the running address stepped by 4 before the access. With `pre_i`=0 the access uses the running address, which is stepped by 4 afterwards. The running address starts at `base_i`.
- R3: With `up_i`=1 the selected registers are visited in ascending index order and the address increases. With `up_i`=0 they are visited in descending index order and the address decreases.
- R4: Exactly one 32-bit word access is made for each set mask bit and none for clear bits. Consecutive accesses differ by exactly 4 bytes, and registers outside the mask are never written.
- R5: With `load_i`=1 each access is a read (`mem_we_o`=0), and the read word is written to register `rf_idx_o` in the cycle ready is high. With `load_i`=0 each access is a write carrying the current value of register `rf_idx_o`.
- R6: When `wb_i`=1 and the instruction is not refused, the DONE cycle raises `base_wb_o` with `base_addr_o` equal to the final running address, base ± 4 × (number of selected registers). With `wb_i`=0, `base_wb_o` stays low.
- R7: An empty mask completes with `done_o` in the cycle after the start and makes no memory access. It still raises the writeback, carrying `base_i`, when `wb_i`=1.
- R8: An access holds its request, address and direction until `mem_rdy_i` is high. The sequence advances only on a ready cycle.
- R9: `done_o` is high for exactly one cycle, one cycle after the ready of the last access. `busy_o` is high from the cycle after an accepted start through the `done_o` cycle.
- R10: `start_i` is ignored while `busy_o` is high, including in the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an instruction (taken only when idle) |
| base_i | input | 32 | Base address |
| rlist_i | input | 16 | Register-select mask, bit n selects register n |
| pre_i | input | 1 | 1: step before access, 0: step after |
| up_i | input | 1 | 1: ascending order and address, 0: descending |
| priv_i | input | 1 | Privileged-bank request (refused) |
| wb_i | input | 1 | Request base writeback |
| load_i | input | 1 | 1: memory to registers, 0: registers to memory |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 1 | Undefined-encoding trap, valid with done_o |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Access byte address |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data |
| mem_rdy_i | input | 1 | Access completes this cycle |
| rf_idx_o | output | 4 | Register-file index of the current access |
| rf_rdata_i | input | 32 | Register-file read data at rf_idx_o |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_wdata_o | output | 32 | Register-file write data |
| base_wb_o | output | 1 | Base writeback strobe |
| base_addr_o | output | 32 | Final running address for writeback |

## Verification
Two things share one cycle on a load. The memory ready completes the current access and writes the register file in that same cycle, and the same ready also decides whether the controller stays in XFER or moves to DONE. The bench provokes both by mixing single-register masks, full masks and ready patterns with stalls. A cycle-level model built from queues of expected addresses and indices judges, on every clock, whether the register write and the move to the next access happen together. It also checks that the completion pulse follows exactly one cycle after the last ready. A second coincidence is a start pulse landing in the DONE cycle, when the block is still busy. The model expects that start to be dropped and checks for idle on the next clock.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2,
        ST_TRAP = 2'd3
    } xfer_state_e;

    typedef struct packed {
        logic pre;
        logic up;
        logic wb;
        logic load;
    } xfer_ctl_t;

endpackage

// File: rtl/blk_xfer_pick.sv
// Chooses the next register to transfer from the pending mask.
// Ascending picks the lowest set bit, descending the highest.
module blk_xfer_pick #(
    parameter int NREG = 16,
    parameter int IW   = $clog2(NREG)
) (
    input  logic [NREG-1:0] mask_i,
    input  logic            up_i,
    output logic            any_o,
    output logic [IW-1:0]   idx_o,
    output logic            last_o
);

    logic [NREG-1:0] mask_less;

    // The last match in the scan wins, so scan away from the wanted end.
    always_comb begin
        idx_o = '0;
        if (up_i) begin
            for (int i = NREG - 1; i >= 0; i--) begin
                if (mask_i[i]) idx_o = IW'(i);
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (mask_i[i]) idx_o = IW'(i);
            end
        end
    end

    assign mask_less = mask_i & (mask_i - NREG'(1));
    assign any_o     = |mask_i;
    assign last_o    = any_o && (mask_less == '0);

endmodule

// File: rtl/blk_xfer_addr.sv
// Computes the access address and the next running address.
module blk_xfer_addr #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] cur_i,
    input  logic          up_i,
    input  logic          pre_i,
    output logic [AW-1:0] acc_o,
    output logic [AW-1:0] nxt_o
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    assign nxt_o = up_i ? (cur_i + STEP_V) : (cur_i - STEP_V);
    assign acc_o = pre_i ? nxt_o : cur_i;

endmodule

// File: rtl/blk_xfer_fsm.sv
module blk_xfer_fsm
    import blk_xfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        illegal_i,
    input  logic        empty_i,
    input  logic        beat_i,
    input  logic        last_i,
    output xfer_state_e state_o
);

    xfer_state_e state_q;
    xfer_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (illegal_i)    state_d = ST_TRAP;
                    else if (empty_i) state_d = ST_DONE;
                    else              state_d = ST_XFER;
                end
            end
            ST_XFER: begin
                if (beat_i && last_i) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            ST_TRAP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int STEP = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [AW-1:0]            base_i,
    input  logic [NREG-1:0]          rlist_i,
    input  logic                     pre_i,
    input  logic                     up_i,
    input  logic                     priv_i,
    input  logic                     wb_i,
    input  logic                     load_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     trap_o,
    output logic                     mem_req_o,
    output logic                     mem_we_o,
    output logic [AW-1:0]            mem_addr_o,
    output logic [DW-1:0]            mem_wdata_o,
    input  logic [DW-1:0]            mem_rdata_i,
    input  logic                     mem_rdy_i,
    output logic [$clog2(NREG)-1:0]  rf_idx_o,
    input  logic [DW-1:0]            rf_rdata_i,
    output logic                     rf_we_o,
    output logic [DW-1:0]            rf_wdata_o,
    output logic                     base_wb_o,
    output logic [AW-1:0]            base_addr_o
);

    localparam int IW      = $clog2(NREG);
    localparam int TOP_IDX = NREG - 1;

    xfer_state_e      state;
    xfer_ctl_t        ctl_q;
    logic [NREG-1:0]  pend_q;
    logic [AW-1:0]    addr_q;
    logic             pick_any;
    logic [IW-1:0]    pick_idx;
    logic             pick_last;
    logic [AW-1:0]    acc_addr;
    logic [AW-1:0]    nxt_addr;
    logic             illegal;
    logic             empty;
    logic             accept;
    logic             beat;

    assign illegal = rlist_i[TOP_IDX] | priv_i;
    assign empty   = (rlist_i == '0);
    assign accept  = start_i && (state == ST_IDLE);
    assign beat    = (state == ST_XFER) && mem_rdy_i && pick_any;

    blk_xfer_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .illegal_i (illegal),
        .empty_i   (empty),
        .beat_i    (beat),
        .last_i    (pick_last),
        .state_o   (state)
    );

    blk_xfer_pick #(.NREG(NREG), .IW(IW)) u_pick (
        .mask_i (pend_q),
        .up_i   (ctl_q.up),
        .any_o  (pick_any),
        .idx_o  (pick_idx),
        .last_o (pick_last)
    );

    blk_xfer_addr #(.AW(AW), .STEP(STEP)) u_addr (
        .cur_i (addr_q),
        .up_i  (ctl_q.up),
        .pre_i (ctl_q.pre),
        .acc_o (acc_addr),
        .nxt_o (nxt_addr)
    );

    // Datapath registers: captured on accept, advanced on each beat.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            addr_q <= '0;
            ctl_q  <= '0;
        end else if (accept) begin
            pend_q <= illegal ? '0 : rlist_i;
            addr_q <= base_i;
            ctl_q  <= '{pre: pre_i, up: up_i, wb: wb_i, load: load_i};
        end else if (beat) begin
            pend_q[pick_idx] <= 1'b0;
            addr_q           <= nxt_addr;
        end
    end

    // Output decode by state.
    always_comb begin
        busy_o      = 1'b0;
        done_o      = 1'b0;
        trap_o      = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        rf_idx_o    = pick_idx;
        rf_we_o     = 1'b0;
        rf_wdata_o  = '0;
        base_wb_o   = 1'b0;
        base_addr_o = '0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_XFER: begin
                busy_o     = 1'b1;
                mem_req_o  = 1'b1;
                mem_we_o   = !ctl_q.load;
                mem_addr_o = acc_addr;
                if (!ctl_q.load) mem_wdata_o = rf_rdata_i;
                if (ctl_q.load && mem_rdy_i) begin
                    rf_we_o    = 1'b1;
                    rf_wdata_o = mem_rdata_i;
                end
            end
            ST_DONE: begin
                busy_o      = 1'b1;
                done_o      = 1'b1;
                base_wb_o   = ctl_q.wb;
                base_addr_o = ctl_q.wb ? addr_q : '0;
            end
            ST_TRAP: begin
                busy_o = 1'b1;
                done_o = 1'b1;
                trap_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/blk_xfer_chk.sv
module blk_xfer_chk #(
    parameter int NREG = 16,
    parameter int AW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [NREG-1:0] rlist_i,
    input logic            priv_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            trap_o,
    input logic            mem_req_o,
    input logic            mem_rdy_i,
    input logic            mem_we_o,
    input logic [AW-1:0]   mem_addr_o,
    input logic            rf_we_o,
    input logic            base_wb_o
);

    assert_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (rlist_i[NREG-1] || priv_i)) |=> (trap_o && done_o && !mem_req_o));

    assert_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (rlist_i == '0) && !priv_i) |=> (done_o && !trap_o && !mem_req_o));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_load_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (mem_req_o && mem_rdy_i && !mem_we_o));

    assert_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        base_wb_o |-> (done_o && !trap_o));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_rdy_i) |=> (!mem_req_o
            || (mem_addr_o == $past(mem_addr_o) + AW'(4))
            || (mem_addr_o == $past(mem_addr_o) - AW'(4))));

    assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (busy_o && !done_o));

endmodule

bind blk_xfer_seq blk_xfer_chk #(.NREG(NREG), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rlist_i    (rlist_i),
    .priv_i     (priv_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .trap_o     (trap_o),
    .mem_req_o  (mem_req_o),
    .mem_rdy_i  (mem_rdy_i),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .rf_we_o    (rf_we_o),
    .base_wb_o  (base_wb_o)
);

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] rlist_i = '0;
    logic        pre_i = 1'b0, up_i = 1'b0, priv_i = 1'b0, wb_i = 1'b0, load_i = 1'b0;
    logic        busy_o, done_o, trap_o, mem_req_o, mem_we_o, mem_rdy_i;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic [3:0]  rf_idx_o;
    logic [31:0] rf_rdata_i, rf_wdata_o, base_addr_o;
    logic        rf_we_o, base_wb_o;

    logic [31:0] mem [0:255];
    logic [31:0] rf  [0:15];
    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    assign mem_rdata_i = mem[mem_addr_o[9:2]];
    assign rf_rdata_i  = rf[rf_idx_o];

    blk_xfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .rlist_i(rlist_i),
        .pre_i(pre_i), .up_i(up_i), .priv_i(priv_i), .wb_i(wb_i), .load_i(load_i),
        .busy_o(busy_o), .done_o(done_o), .trap_o(trap_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i),
        .rf_idx_o(rf_idx_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
        .rf_wdata_o(rf_wdata_o), .base_wb_o(base_wb_o), .base_addr_o(base_addr_o)
    );

    always @(posedge clk) begin
        if (mem_req_o && mem_rdy_i && mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
        if (rf_we_o) rf[rf_idx_o] <= rf_wdata_o;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    function automatic logic [31:0] mem_seed(input int w);
        return {16'hA55A ^ 16'(w), 16'h0F00 + 16'(w)};
    endfunction

    function automatic logic [31:0] rf_seed(input int i);
        return 32'h1100_0000 + (32'(i) * 32'h0001_0101);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic seed_all();
        for (int j = 0; j < 256; j++) mem[j] = mem_seed(j);
        for (int i = 0; i < 16; i++) rf[i] = rf_seed(i);
    endtask

    function automatic logic rdy_pat(input int mode, input int n);
        case (mode)
            0: return 1'b1;
            1: return (n % 3) != 1;
            default: return (n % 5) == 4;
        endcase
    endfunction

    task automatic run_op(input logic [31:0] base, input logic [15:0] list,
                          input bit p, input bit u, input bit s, input bit w, input bit l,
                          input int stall, input bit poke);
        logic [31:0] qa[$];
        int          qi[$];
        logic [31:0] sa[$];
        int          si[$];
        logic [31:0] a;
        logic [31:0] fin;
        bit          bad;
        int          n;
        n = 0;
        seed_all();
        bad = list[15] | s;
        a = base;
        if (!bad) begin
            if (u) begin
                for (int i = 0; i < 16; i++) if (list[i]) begin
                    if (p) a = a + 4;
                    qa.push_back(a); qi.push_back(i);
                    if (!p) a = a + 4;
                end
            end else begin
                for (int i = 15; i >= 0; i--) if (list[i]) begin
                    if (p) a = a - 4;
                    qa.push_back(a); qi.push_back(i);
                    if (!p) a = a - 4;
                end
            end
        end
        fin = a;
        sa = qa; si = qi;

        @(negedge clk);
        start_i = 1'b1; base_i = base; rlist_i = list;
        pre_i = p; up_i = u; priv_i = s; wb_i = w; load_i = l; mem_rdy_i = 1'b0;
        #1;
        chk("R9", "busy before accept", 32'(busy_o), 32'd0);

        forever begin
            @(negedge clk);
            start_i = poke;
            base_i  = 32'h0000_0300; rlist_i = 16'h0003; priv_i = 1'b0;
            pre_i = ~p; up_i = ~u; wb_i = 1'b1; load_i = ~l;
            mem_rdy_i = rdy_pat(stall, n);
            #1;
            if (qa.size() > 0) begin
                chk("R4", "request active", 32'(mem_req_o), 32'd1);
                chk("R9", "no early done", 32'(done_o), 32'd0);
                chk("R2", "access address", mem_addr_o, qa[0]);
                chk("R3", "register order", 32'(rf_idx_o), 32'(qi[0]));
                chk("R5", "direction", 32'(mem_we_o), 32'(!l));
                if (!l) chk("R5", "store data", mem_wdata_o, rf_seed(qi[0]));
                if (mem_rdy_i) begin
                    chk("R5", "load write strobe", 32'(rf_we_o), 32'(l));
                    if (l) chk("R5", "load data", rf_wdata_o, mem_seed(int'(qa[0][9:2])));
                    void'(qa.pop_front());
                    void'(qi.pop_front());
                end else begin
                    chk("R8", "no write while stalled", 32'(rf_we_o), 32'd0);
                end
            end else begin
                chk("R9", "done pulse", 32'(done_o), 32'd1);
                chk("R1", "trap flag", 32'(trap_o), 32'(bad));
                chk("R4", "no extra access", 32'(mem_req_o), 32'd0);
                chk("R6", "writeback strobe", 32'(base_wb_o), 32'(w && !bad));
                if (w && !bad) chk("R6", "writeback address", base_addr_o, fin);
                break;
            end
            n++;
            if (n > 400) begin
                chk("R8", "sequence finished", 32'd0, 32'd1);
                break;
            end
        end

        @(negedge clk);
        start_i = 1'b0; mem_rdy_i = 1'b0;
        #1;
        chk("R9", "done cleared", 32'(done_o), 32'd0);
        chk("R10", "idle after done, late start ignored", 32'(busy_o), 32'd0);

        for (int k = 0; k < sa.size(); k++) begin
            if (l) chk("R5", "register loaded", rf[si[k]], mem_seed(int'(sa[k][9:2])));
            else   chk("R5", "memory stored", mem[sa[k][9:2]], rf_seed(si[k]));
        end
        if (l || bad) begin
            for (int i = 0; i < 16; i++) if (bad || !list[i])
                chk("R4", "unselected register untouched", rf[i], rf_seed(i));
        end
    endtask

    initial begin
        mem_rdy_i = 1'b0;
        seed_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9", "reset busy", 32'(busy_o), 32'd0);
        chk("R9", "reset done", 32'(done_o), 32'd0);
        chk("R4", "reset request", 32'(mem_req_o), 32'd0);
        chk("R6", "reset writeback", 32'(base_wb_o), 32'd0);

        // R2 R3: all four step/direction combinations, loads and stores
        for (int c = 0; c < 4; c++) begin
            run_op(32'h0000_0100, 16'h41A5, c[1], c[0], 1'b0, 1'b1, 1'b1, 1, 1'b0);
            run_op(32'h0000_0180, 16'h1A52, c[1], c[0], 1'b0, 1'b1, 1'b0, 0, 1'b0);
        end
        // R4: full legal mask, single register, writeback off
        run_op(32'h0000_0200, 16'h7FFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0);
        run_op(32'h0000_0040, 16'h0008, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        // R1: refused encodings
        run_op(32'h0000_0100, 16'h8001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 0, 1'b0);
        run_op(32'h0000_0100, 16'h0011, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0);
        // R7: empty mask with and without writeback
        run_op(32'h0000_0120, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 0, 1'b0);
        run_op(32'h0000_0120, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        // R8: long stalls
        run_op(32'h0000_0300, 16'h0C03, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2, 1'b0);
        // R10: start held high while busy
        run_op(32'h0000_0140, 16'h0306, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1, 1'b1);
        run_op(32'h0000_0140, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 0, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule